// File: doc/BRIEF.md
# Decode-Stage Load-Use Stall and Fetch Flush Controller

This block sits in the decode stage of a five-stage in-order pipeline and owns the two ways the front end is held back. When the instruction in execute is a load and the instruction in decode reads the load's target register, the block freezes the program counter and the fetch/decode register for one cycle. In the same cycle it forces the control fields entering the decode/execute register to zero, so that a no-op bubble travels behind the load. When decode recognises a jump, or resolves a branch that redirects fetch, the block steers the program counter to the new target. It also clears the instruction word captured in the fetch/decode register, so the wrongly fetched instruction becomes a no-op.

The two actions come from different sources and can coincide. A stall wins: the flush and the redirect are held back while the bubble is inserted. The decode instruction is still present in the following cycle and presents its redirect again, and the flush takes effect then. A load whose target is register 0 never stalls.

The register stages the controls act on are part of the block: the program counter, the fetch/decode register (instruction word and its address) and the control part of the decode/execute register. The execute-stage load flag and target come from that last register. Decoded source registers, control fields and redirect requests come in from the surrounding decode logic.

Top module: `ld_hazard_unit`

## Requirements
- R1: `ctrl_zero` is 1 in a cycle exactly when `idex_mem_rd` is 1, `idex_dst` is non-zero, and `idex_dst` equals `id_src_a` or `id_src_b`; the output is combinational within that cycle.
- R2: While `ctrl_zero` is 1, `pc_we` and `ifid_we` are 0, and after the clock edge `pc`, `ifid_instr` and `ifid_pc` keep their previous values.
- R3: At an edge where `ctrl_zero` is 1, `idex_ctrl` and `idex_mem_rd` are loaded with zero, and `idex_dst` still takes `id_dst`.
- R4: A load-use stall lasts exactly one cycle: the cycle after a stall never stalls.
- R5: With `id_jump` at 1 and no stall, `ifid_flush` is 1, and after the edge `ifid_instr` is all zeros (the no-op encoding), `ifid_pc` holds the address that was being fetched, and `pc` equals `id_target`.
- R6: With `id_br_redir` at 1 and no stall, the result is the same as R5: one flushed fetch slot, and `pc` takes `id_target`.
- R7: Without a stall, `idex_ctrl` and `idex_mem_rd` take `id_ctrl` and `id_mem_rd` unchanged, including in a cycle that flushes the fetch slot.
- R8: When a stall and a redirect request coincide, `ifid_flush` and `pc_we` are 0. The flush and the redirect occur in the next cycle if decode still requests them.
- R9: A load whose target register is 0 does not raise `ctrl_zero`, even when a source register is 0.
- R10: While `rst` is 1, `pc` becomes `RESET_PC`, and `ifid_instr`, `ifid_pc`, `idex_ctrl`, `idex_mem_rd` and `idex_dst` become zero.
- R11: With no stall and no redirect, `pc` advances by `PC_STEP`, `ifid_instr` takes `if_instr`, and `ifid_pc` takes the old `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_instr | input | IW | Instruction word read at `pc` |
| id_src_a | input | RAW | First source register of the decode instruction |
| id_src_b | input | RAW | Second source register of the decode instruction |
| id_ctrl | input | CW | Execute/memory/writeback control fields of the decode instruction |
| id_mem_rd | input | 1 | Decode instruction reads memory (load) |
| id_dst | input | RAW | Target register of the decode instruction |
| id_jump | input | 1 | Decode instruction is a jump |
| id_br_redir | input | 1 | Branch resolved in decode redirects fetch |
| id_target | input | PW | Redirect address for a jump or branch |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctrl_zero | output | 1 | Selects zero control fields into decode/execute (stall) |
| ifid_flush | output | 1 | Clears the instruction word entering fetch/decode |
| pc | output | PW | Program counter |
| ifid_instr | output | IW | Instruction word held in fetch/decode |
| ifid_pc | output | PW | Address held in fetch/decode |
| idex_ctrl | output | CW | Control fields held in decode/execute |
| idex_mem_rd | output | 1 | Load flag held in decode/execute |
| idex_dst | output | RAW | Target register held in decode/execute |

## Verification
The bench builds the block with a 16-bit program counter, a 6-bit control field, 32-bit instructions and 5-bit register indices, and with a non-zero reset address. With these values every register index, register 0 included, can be compared cheaply. Redirect targets are short enough to read at a glance in failure lines. The directed part places a load ahead of a use on each source port in turn, a load with no use, and a non-load whose target matches a source. It also covers a load to register 0 against a register-0 source, a jump, a branch redirect, and a stall that coincides with a jump. A long pseudo-random run then draws register indices from a range of four values, so that matches, register-0 cases and coinciding events occur often.

// File: rtl/ld_hazard_pkg.sv
package ld_hazard_pkg;

  // Source of the next program counter value.
  typedef enum logic [1:0] {
    PCS_HOLD  = 2'd0,
    PCS_SEQ   = 2'd1,
    PCS_REDIR = 2'd2
  } pc_src_e;

  // Number of register operands an instruction in decode can read.
  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/lu_detect.sv
module lu_detect #(
  parameter int unsigned RAW  = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic                ex_mem_rd,
  input  logic [RAW-1:0]      ex_dst,
  input  logic [NSRC*RAW-1:0] id_srcs,
  output logic                stall
);

  logic [NSRC-1:0] hit;

  // One comparator per decode-stage source operand.
  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign hit[i] = (ex_dst == id_srcs[i*RAW +: RAW]);
  end

  // Register 0 is never a real producer, so it cannot cause a stall.
  assign stall = ex_mem_rd && (ex_dst != '0) && (|hit);

endmodule

// File: rtl/redir_ctl.sv
module redir_ctl
  import ld_hazard_pkg::*;
(
  input  logic    stall,
  input  logic    jump,
  input  logic    br_redir,
  output logic    pc_we,
  output logic    ifid_we,
  output logic    ctrl_zero,
  output logic    ifid_flush,
  output pc_src_e pc_sel
);

  logic redirect;

  assign redirect = jump | br_redir;

  always_comb begin
    // Stall wins: freeze the front end and hold any redirect back.
    pc_we      = !stall;
    ifid_we    = !stall;
    ctrl_zero  = stall;
    ifid_flush = redirect && !stall;
    if (stall)         pc_sel = PCS_HOLD;
    else if (redirect) pc_sel = PCS_REDIR;
    else               pc_sel = PCS_SEQ;
  end

endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
  import ld_hazard_pkg::*;
#(
  parameter int unsigned   IW       = 32,
  parameter int unsigned   PW       = 32,
  parameter logic [PW-1:0] RESET_PC = '0,
  parameter int unsigned   PC_STEP  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  pc_src_e       pc_sel,
  input  logic [PW-1:0] target,
  input  logic [IW-1:0] fetch_instr,
  input  logic          ifid_we,
  input  logic          ifid_flush,
  output logic [PW-1:0] pc_q,
  output logic [IW-1:0] ifid_instr_q,
  output logic [PW-1:0] ifid_pc_q
);

  localparam logic [PW-1:0] STEP = PW'(PC_STEP);
  localparam logic [IW-1:0] NOP  = '0;

  logic [PW-1:0] pc_nxt;

  always_comb begin
    case (pc_sel)
      PCS_SEQ:   pc_nxt = pc_q + STEP;
      PCS_REDIR: pc_nxt = target;
      default:   pc_nxt = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ifid_instr_q <= NOP;
      ifid_pc_q    <= '0;
    end else if (ifid_we) begin
      ifid_instr_q <= ifid_flush ? NOP : fetch_instr;
      ifid_pc_q    <= pc_q;
    end
  end

endmodule

// File: rtl/idex_regs.sv
module idex_regs #(
  parameter int unsigned CW  = 8,
  parameter int unsigned RAW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bubble,
  input  logic [CW-1:0]  d_ctrl,
  input  logic           d_mem_rd,
  input  logic [RAW-1:0] d_dst,
  output logic [CW-1:0]  q_ctrl,
  output logic           q_mem_rd,
  output logic [RAW-1:0] q_dst
);

  // The load flag is one more control bit; the bubble clears them all.
  localparam int unsigned FW = CW + 1;

  logic [FW-1:0] fields_d;
  logic [FW-1:0] fields_q;

  assign fields_d = bubble ? '0 : {d_mem_rd, d_ctrl};

  always_ff @(posedge clk) begin
    if (rst) begin
      fields_q <= '0;
      q_dst    <= '0;
    end else begin
      fields_q <= fields_d;
      q_dst    <= d_dst;
    end
  end

  assign q_ctrl   = fields_q[CW-1:0];
  assign q_mem_rd = fields_q[CW];

endmodule

// File: rtl/ld_hazard_unit.sv
module ld_hazard_unit
  import ld_hazard_pkg::*;
#(
  parameter int unsigned   RAW      = 5,
  parameter int unsigned   IW       = 32,
  parameter int unsigned   PW       = 32,
  parameter int unsigned   CW       = 8,
  parameter logic [PW-1:0] RESET_PC = '0,
  parameter int unsigned   PC_STEP  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IW-1:0]  if_instr,
  input  logic [RAW-1:0] id_src_a,
  input  logic [RAW-1:0] id_src_b,
  input  logic [CW-1:0]  id_ctrl,
  input  logic           id_mem_rd,
  input  logic [RAW-1:0] id_dst,
  input  logic           id_jump,
  input  logic           id_br_redir,
  input  logic [PW-1:0]  id_target,
  output logic           pc_we,
  output logic           ifid_we,
  output logic           ctrl_zero,
  output logic           ifid_flush,
  output logic [PW-1:0]  pc,
  output logic [IW-1:0]  ifid_instr,
  output logic [PW-1:0]  ifid_pc,
  output logic [CW-1:0]  idex_ctrl,
  output logic           idex_mem_rd,
  output logic [RAW-1:0] idex_dst
);

  logic    lu_stall;
  pc_src_e pc_sel;

  lu_detect #(
    .RAW  (RAW),
    .NSRC (NUM_SRC)
  ) u_detect (
    .ex_mem_rd (idex_mem_rd),
    .ex_dst    (idex_dst),
    .id_srcs   ({id_src_b, id_src_a}),
    .stall     (lu_stall)
  );

  redir_ctl u_redir (
    .stall      (lu_stall),
    .jump       (id_jump),
    .br_redir   (id_br_redir),
    .pc_we      (pc_we),
    .ifid_we    (ifid_we),
    .ctrl_zero  (ctrl_zero),
    .ifid_flush (ifid_flush),
    .pc_sel     (pc_sel)
  );

  fetch_regs #(
    .IW       (IW),
    .PW       (PW),
    .RESET_PC (RESET_PC),
    .PC_STEP  (PC_STEP)
  ) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .pc_sel       (pc_sel),
    .target       (id_target),
    .fetch_instr  (if_instr),
    .ifid_we      (ifid_we),
    .ifid_flush   (ifid_flush),
    .pc_q         (pc),
    .ifid_instr_q (ifid_instr),
    .ifid_pc_q    (ifid_pc)
  );

  idex_regs #(
    .CW  (CW),
    .RAW (RAW)
  ) u_idex (
    .clk      (clk),
    .rst      (rst),
    .bubble   (ctrl_zero),
    .d_ctrl   (id_ctrl),
    .d_mem_rd (id_mem_rd),
    .d_dst    (id_dst),
    .q_ctrl   (idex_ctrl),
    .q_mem_rd (idex_mem_rd),
    .q_dst    (idex_dst)
  );

endmodule

// File: rtl/ld_hazard_unit_chk.sv
module ld_hazard_unit_chk #(
  parameter int unsigned RAW = 5,
  parameter int unsigned IW  = 32,
  parameter int unsigned PW  = 32,
  parameter int unsigned CW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [CW-1:0]  id_ctrl,
  input logic           id_jump,
  input logic           id_br_redir,
  input logic [PW-1:0]  id_target,
  input logic           pc_we,
  input logic           ctrl_zero,
  input logic           ifid_flush,
  input logic [PW-1:0]  pc,
  input logic [IW-1:0]  ifid_instr,
  input logic [PW-1:0]  ifid_pc,
  input logic [CW-1:0]  idex_ctrl,
  input logic           idex_mem_rd,
  input logic [RAW-1:0] idex_dst
);

  // R2: a stall freezes the program counter and the fetch/decode register.
  p_freeze_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_zero |=> ($stable(pc) && $stable(ifid_instr) && $stable(ifid_pc)));

  // R3: the stall edge loads a bubble into the control part of decode/execute.
  p_bubble_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_zero |=> (idex_ctrl == '0 && !idex_mem_rd));

  // R4: never two stall cycles in a row.
  p_single_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl_zero |=> !ctrl_zero);

  // R5 / R6: a flush leaves a no-op in fetch/decode and the redirect address in pc.
  p_flush_nop_r5: assert property (@(posedge clk) disable iff (rst)
    ifid_flush |=> (ifid_instr == '0));

  p_redir_pc_r6: assert property (@(posedge clk) disable iff (rst)
    (ifid_flush && (id_jump || id_br_redir)) |=> (pc == $past(id_target)));

  // R7: without a stall the decode control fields pass into decode/execute intact.
  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrl_zero |=> (idex_ctrl == $past(id_ctrl)));

  // R8: a stall suppresses the flush and the program counter write.
  p_prio_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl_zero |-> (!ifid_flush && !pc_we));

  // R9: a register-0 target in execute never stalls.
  p_zero_dst_r9: assert property (@(posedge clk) disable iff (rst)
    (idex_dst == '0) |-> !ctrl_zero);

endmodule

bind ld_hazard_unit ld_hazard_unit_chk #(
  .RAW (RAW),
  .IW  (IW),
  .PW  (PW),
  .CW  (CW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .id_ctrl     (id_ctrl),
  .id_jump     (id_jump),
  .id_br_redir (id_br_redir),
  .id_target   (id_target),
  .pc_we       (pc_we),
  .ctrl_zero   (ctrl_zero),
  .ifid_flush  (ifid_flush),
  .pc          (pc),
  .ifid_instr  (ifid_instr),
  .ifid_pc     (ifid_pc),
  .idex_ctrl   (idex_ctrl),
  .idex_mem_rd (idex_mem_rd),
  .idex_dst    (idex_dst)
);

// File: tb/sim_ld_hazard_unit.sv
`timescale 1ns/1ps
module sim_ld_hazard_unit;

  localparam int CLK_PERIOD = 10;
  localparam int RAW = 5;
  localparam int IW  = 32;
  localparam int PW  = 16;
  localparam int CW  = 6;
  localparam logic [PW-1:0] RST_PC = 16'h0040;
  localparam int STEP = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [IW-1:0]  if_instr = '0;
  logic [RAW-1:0] id_src_a = '0, id_src_b = '0, id_dst = '0;
  logic [CW-1:0]  id_ctrl = '0;
  logic           id_mem_rd = 1'b0, id_jump = 1'b0, id_br_redir = 1'b0;
  logic [PW-1:0]  id_target = '0;
  logic           pc_we, ifid_we, ctrl_zero, ifid_flush, idex_mem_rd;
  logic [PW-1:0]  pc, ifid_pc;
  logic [IW-1:0]  ifid_instr;
  logic [CW-1:0]  idex_ctrl;
  logic [RAW-1:0] idex_dst;

  ld_hazard_unit #(.RAW(RAW), .IW(IW), .PW(PW), .CW(CW),
                   .RESET_PC(RST_PC), .PC_STEP(STEP)) u0 (
    .clk(clk), .rst(rst), .if_instr(if_instr), .id_src_a(id_src_a),
    .id_src_b(id_src_b), .id_ctrl(id_ctrl), .id_mem_rd(id_mem_rd),
    .id_dst(id_dst), .id_jump(id_jump), .id_br_redir(id_br_redir),
    .id_target(id_target), .pc_we(pc_we), .ifid_we(ifid_we),
    .ctrl_zero(ctrl_zero), .ifid_flush(ifid_flush), .pc(pc),
    .ifid_instr(ifid_instr), .ifid_pc(ifid_pc), .idex_ctrl(idex_ctrl),
    .idex_mem_rd(idex_mem_rd), .idex_dst(idex_dst));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  int m_pc, m_ifi, m_ifp, m_ctrl, m_mrd, m_dst;
  bit prev_stall = 1'b0;
  int seq = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one decode-stage situation; input changes happen at the falling edge.
  task automatic step(input int sa, input int sb, input int ct, input bit mr,
                      input int dd, input bit jj, input bit bb, input int tg);
    bit e_stall, e_flush;
    string t, st_tag, ex_tag;
    int ins;
    seq++;
    ins = 32'h1000_0000 + seq;
    if_instr = IW'(ins); id_src_a = RAW'(sa); id_src_b = RAW'(sb);
    id_ctrl = CW'(ct); id_mem_rd = mr; id_dst = RAW'(dd);
    id_jump = jj; id_br_redir = bb; id_target = PW'(tg);
    #1;
    e_stall = (m_mrd != 0) && (m_dst != 0) && (m_dst == sa || m_dst == sb);
    e_flush = (jj || bb) && !e_stall;
    if (prev_stall) t = "R4";
    else if (m_mrd != 0 && m_dst == 0 && (sa == 0 || sb == 0)) t = "R9";
    else t = "R1";
    chk(t, ctrl_zero, e_stall);
    chk("R2", pc_we, !e_stall);
    chk("R2", ifid_we, !e_stall);
    if (e_stall && (jj || bb)) t = "R8";
    else if (bb) t = "R6";
    else t = "R5";
    chk(t, ifid_flush, e_flush);
    if (!e_stall) begin
      m_ifp = m_pc;
      m_ifi = e_flush ? 0 : ins;
      m_pc  = (jj || bb) ? (tg & 16'hFFFF) : ((m_pc + STEP) & 16'hFFFF);
    end
    m_ctrl = e_stall ? 0 : (ct & 6'h3F);
    m_mrd  = e_stall ? 0 : int'(mr);
    m_dst  = dd & 5'h1F;
    if (e_stall) st_tag = "R2";
    else if (jj) st_tag = "R5";
    else if (bb) st_tag = "R6";
    else st_tag = "R11";
    ex_tag = e_stall ? "R3" : "R7";
    prev_stall = e_stall;
    @(negedge clk);
    chk(st_tag, pc, m_pc);
    chk(st_tag, ifid_instr, m_ifi);
    chk(st_tag, ifid_pc, m_ifp);
    chk(ex_tag, idex_ctrl, m_ctrl);
    chk(ex_tag, idex_mem_rd, m_mrd);
    chk(ex_tag, idex_dst, m_dst);
  endtask

  // Watchdog: a hung run counts as a failed check.
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset values.
    chk("R10", pc, RST_PC);
    chk("R10", ifid_instr, 0);
    chk("R10", ifid_pc, 0);
    chk("R10", idex_ctrl, 0);
    chk("R10", idex_mem_rd, 0);
    chk("R10", idex_dst, 0);
    m_pc = RST_PC; m_ifi = 0; m_ifp = 0; m_ctrl = 0; m_mrd = 0; m_dst = 0;
    rst = 1'b0;

    // R11: plain sequential flow.
    step(1, 2, 6'h11, 0, 7, 0, 0, 0);
    step(3, 4, 6'h12, 0, 8, 0, 0, 0);
    // R1/R2/R3/R4: load to r5, then use on source A.
    step(1, 2, 6'h21, 1, 5, 0, 0, 0);
    step(5, 9, 6'h22, 0, 6, 0, 0, 0);
    step(5, 9, 6'h22, 0, 6, 0, 0, 0);
    // Use on source B.
    step(0, 0, 6'h23, 1, 12, 0, 0, 0);
    step(3, 12, 6'h24, 0, 2, 0, 0, 0);
    step(3, 12, 6'h24, 0, 2, 0, 0, 0);
    // Load with no consumer; non-load with a matching target.
    step(0, 0, 6'h25, 1, 14, 0, 0, 0);
    step(1, 2, 6'h26, 0, 3, 0, 0, 0);
    step(3, 3, 6'h27, 0, 4, 0, 0, 0);
    // R9: load to r0 against an r0 source.
    step(1, 1, 6'h28, 1, 0, 0, 0, 0);
    step(0, 0, 6'h29, 0, 1, 0, 0, 0);
    // R5: jump; R6: branch redirect.
    step(1, 2, 6'h2A, 0, 1, 1, 0, 16'h0200);
    step(1, 2, 6'h2B, 0, 1, 0, 0, 0);
    step(1, 2, 6'h2C, 0, 1, 0, 1, 16'h0300);
    step(1, 2, 6'h2D, 0, 1, 0, 0, 0);
    // R8: stall coinciding with a jump, then the deferred flush.
    step(0, 0, 6'h2E, 1, 9, 0, 0, 0);
    step(9, 1, 6'h2F, 0, 2, 1, 0, 16'h0400);
    step(9, 1, 6'h2F, 0, 2, 1, 0, 16'h0400);
    step(1, 2, 6'h30, 0, 1, 0, 0, 0);
    // Stall coinciding with a branch redirect.
    step(0, 0, 6'h31, 1, 3, 0, 0, 0);
    step(2, 3, 6'h32, 0, 2, 0, 1, 16'h0500);
    step(2, 3, 6'h32, 0, 2, 0, 1, 16'h0500);

    // Pseudo-random mix over a small register range.
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(int'(lf[1:0]), int'(lf[3:2]), int'(lf[9:4]), lf[10],
           int'(lf[12:11]), lf[13] & lf[14], lf[15] & lf[5],
           int'({lf[7:0], 2'b00}));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule